// File: doc/BRIEF.md
# Grouped Event Selector

This block decides which hardware event each general-purpose counter observes. Events are laid out as a matrix with eight group columns. Each group delivers at most one event per cycle, and that event carries an 8-bit code, a subunit number and an origin class. Selection happens in two levels. A shared 64-bit selection register holds one code byte per group, so only one code per group can be live at any time. Each counter then names only the group column it follows, and a per-counter filter register admits or rejects that event by its subunit and origin.

Software programs the block through a simple register write port and reads it back through a combinational read port. To change one group's code it reads a 32-bit half, replaces the byte and writes the half back. For each counter the block produces an increment pulse in the same cycle as the matching event. The counters themselves are outside this block.

Top module: `evsel_top`

## Requirements
- R1: The selection register is written and read in two 32-bit halves: address 0x410 holds bits 31:0 and address 0x411 holds bits 63:32. A write to one half leaves the other half unchanged.
- R2: Group g (0 to 7) owns selection bits 8g+7:8g. A counter following group g pulses only when that group's valid strobe is high and its incoming code equals that byte.
- R3: Selection bit 63 is a global enable. While it is clear, no increment output pulses, whatever the events are.
- R4: Counter i has a type register at 0x424 + 0x10*i. Its bits 3:0 name a group. The values 8 to 15 select no event, so that counter never pulses.
- R5: Counter i has a filter register at 0x423 + 0x10*i. Bits 19:17 accept subunits 0, 1 and 2 (bit 17+s for subunit s). Bits 2:0 accept origin classes 0, 1 and 2 (bit o for class o; class 2 is origin-independent). Subunit 3 and origin class 3 are never accepted. The value 0x000E0007 accepts every subunit and every origin.
- R6: The increment output is combinational: it rises in the same cycle as the matching event. Every counter that follows the same group sees the same event, and each one applies its own filter.
- R7: After reset the selection register reads 0, every type register reads 0xF (no event) and every filter register reads 0.
- R8: Writes to addresses that map to no register change no register value.
- R9: Unimplemented bits read as zero. A type register reads back only bits 3:0, and a filter register reads back only bits 19:17 and 2:0.
- R10: A register write takes effect at the clock edge that ends its cycle. An event presented in the same cycle as the write is judged against the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read address |
| rd_data | output | 32 | Combinational read data |
| evt_valid | input | 8 | Per-group event strobe |
| evt_code | input | 64 | Per-group 8-bit event code, group g at bits 8g+7:8g |
| evt_sub | input | 16 | Per-group 2-bit subunit number |
| evt_org | input | 16 | Per-group 2-bit origin class |
| ctr_inc | output | NUM_CTRS | One increment pulse per counter |

## Verification
The function pair that can collide is reconfiguration and matching. A write to a selection half, a type register or a filter register can arrive in the same cycle as an event that the old or the new setting would count differently. The bench provokes this by rewriting group bytes, enable bits and counter types while it presents events those writes affect. It expects the increment to follow the settings in force before the clock edge, and it expects the following cycle to follow the new settings.

// File: rtl/evsel_pkg.sv
// Package: shared constants, the filter field type and address helpers
// for the grouped event selector. Assumes a 12-bit register address space
// and a 32-bit data path.
package evsel_pkg;
    localparam int          GROUPS     = 8;
    localparam int          CODE_W     = 8;
    localparam int          GRP_W      = 4;
    localparam int          ADDR_W     = 12;
    localparam int          DATA_W     = 32;
    localparam int          SEL_W      = GROUPS * CODE_W;
    localparam int          ENABLE_BIT = SEL_W - 1;
    localparam logic [11:0] SEL_LO_ADDR = 12'h410;
    localparam logic [11:0] SEL_HI_ADDR = 12'h411;
    localparam logic [11:0] CTR_BASE    = 12'h420;

    typedef struct packed {
        logic [2:0] sub_ok;
        logic [2:0] org_ok;
    } filt_t;

    function automatic logic [11:0] type_addr(input int idx);
        return CTR_BASE + 12'(idx * 16) + 12'h4;
    endfunction

    function automatic logic [11:0] filt_addr(input int idx);
        return CTR_BASE + 12'(idx * 16) + 12'h3;
    endfunction
endpackage

// File: rtl/evsel_sel_reg.sv
// Shared selection register: one code byte per group plus a global enable
// in the top bit. Written as two 32-bit halves. Assumes the write address
// is stable while wr_en is high.
module evsel_sel_reg
    import evsel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [SEL_W-1:0]     sel_q
);
    // Store half-word writes into the 64-bit selection register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == SEL_LO_ADDR)
                sel_q[31:0] <= wr_data;
            else if (wr_addr == SEL_HI_ADDR)
                sel_q[63:32] <= wr_data;
        end
    end
endmodule

// File: rtl/evsel_ctr_cfg.sv
// Per-counter configuration: the group the counter follows and its
// subunit and origin filter. Unimplemented bits are dropped on write.
module evsel_ctr_cfg
    import evsel_pkg::*;
#(
    parameter logic [11:0] TYPE_ADDR = 12'h424,
    parameter logic [11:0] FILT_ADDR = 12'h423
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [GRP_W-1:0]  grp_q,
    output filt_t             filt_q
);
    // Capture type and filter writes addressed to this counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q  <= '1;
            filt_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == TYPE_ADDR)
                grp_q <= wr_data[GRP_W-1:0];
            if (wr_addr == FILT_ADDR)
                filt_q <= '{sub_ok: wr_data[19:17], org_ok: wr_data[2:0]};
        end
    end
endmodule

// File: rtl/evsel_match.sv
// Combinational match for one counter: pick the followed group's event,
// compare its code with the group's selection byte and apply the filter.
// Group numbers 8 and above select nothing.
module evsel_match
    import evsel_pkg::*;
(
    input  logic [SEL_W-1:0]      sel_q,
    input  logic [GRP_W-1:0]      grp,
    input  filt_t                 filt,
    input  logic [GROUPS-1:0]     evt_valid,
    input  logic [SEL_W-1:0]      evt_code,
    input  logic [2*GROUPS-1:0]   evt_sub,
    input  logic [2*GROUPS-1:0]   evt_org,
    output logic                  inc
);
    logic [2:0]        g;
    logic [CODE_W-1:0] code_in;
    logic [CODE_W-1:0] code_sel;
    logic [1:0]        sub;
    logic [1:0]        org;
    logic [3:0]        sub_vec;
    logic [3:0]        org_vec;

    // Select the followed group's fields and form the increment.
    always_comb begin
        g        = grp[2:0];
        code_in  = evt_code[{g, 3'b000} +: CODE_W];
        code_sel = sel_q[{g, 3'b000} +: CODE_W];
        sub      = evt_sub[{g, 1'b0} +: 2];
        org      = evt_org[{g, 1'b0} +: 2];
        sub_vec  = {1'b0, filt.sub_ok};
        org_vec  = {1'b0, filt.org_ok};
        inc      = sel_q[ENABLE_BIT] && !grp[GRP_W-1] && evt_valid[g]
                   && (code_in == code_sel) && sub_vec[sub] && org_vec[org];
    end
endmodule

// File: rtl/evsel_top.sv
// Grouped event selector top: the shared selection register, one
// configuration and match slice per counter, and the combinational
// read-back mux.
module evsel_top
    import evsel_pkg::*;
#(
    parameter int NUM_CTRS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [11:0]          wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [11:0]          rd_addr,
    output logic [31:0]          rd_data,
    input  logic [7:0]           evt_valid,
    input  logic [63:0]          evt_code,
    input  logic [15:0]          evt_sub,
    input  logic [15:0]          evt_org,
    output logic [NUM_CTRS-1:0]  ctr_inc
);
    localparam int GRP_FLAT_W = NUM_CTRS * GRP_W;

    logic [SEL_W-1:0]      sel_q;
    logic [GRP_W-1:0]      grp_q  [NUM_CTRS];
    filt_t                 filt_q [NUM_CTRS];
    logic [GRP_FLAT_W-1:0] grp_flat;

    evsel_sel_reg u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sel_q   (sel_q)
    );

    for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
        evsel_ctr_cfg #(
            .TYPE_ADDR (type_addr(i)),
            .FILT_ADDR (filt_addr(i))
        ) u_cfg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .grp_q   (grp_q[i]),
            .filt_q  (filt_q[i])
        );

        evsel_match u_match (
            .sel_q     (sel_q),
            .grp       (grp_q[i]),
            .filt      (filt_q[i]),
            .evt_valid (evt_valid),
            .evt_code  (evt_code),
            .evt_sub   (evt_sub),
            .evt_org   (evt_org),
            .inc       (ctr_inc[i])
        );

        assign grp_flat[i*GRP_W +: GRP_W] = grp_q[i];
    end

    // Read-back mux over the selection halves and per-counter registers.
    always_comb begin
        rd_data = '0;
        if (rd_addr == SEL_LO_ADDR)
            rd_data = sel_q[31:0];
        else if (rd_addr == SEL_HI_ADDR)
            rd_data = sel_q[63:32];
        for (int i = 0; i < NUM_CTRS; i++) begin
            if (rd_addr == type_addr(i))
                rd_data = {28'd0, grp_q[i]};
            if (rd_addr == filt_addr(i))
                rd_data = {12'd0, filt_q[i].sub_ok, 14'd0, filt_q[i].org_ok};
        end
    end
endmodule

// File: rtl/evsel_chk.sv
// Checker for the grouped event selector, bound into the top module.
// Assumes the reset is driven low from time zero.
module evsel_chk #(
    parameter int NUM_CTRS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [11:0]            wr_addr,
    input logic [31:0]            wr_data,
    input logic [63:0]            sel_q,
    input logic [NUM_CTRS*4-1:0]  grp_flat,
    input logic [NUM_CTRS-1:0]    ctr_inc
);
    // R3: the global enable gates every increment.
    a_r3_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q[63] |-> ctr_inc == '0);

    // R1: a low-half write lands in bits 31:0.
    a_r1_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 12'h410) |=> sel_q[31:0] == $past(wr_data));

    // R1: a high-half write lands in bits 63:32.
    a_r1_high_half: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 12'h411) |=> sel_q[63:32] == $past(wr_data));

    // R8: writes elsewhere leave the selection register unchanged.
    a_r8_sel_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (wr_addr != 12'h410 && wr_addr != 12'h411)) |=> $stable(sel_q));

    // R7: reset clears the selection register.
    a_r7_reset_clear: assert property (@(posedge clk)
        !rst_n |=> sel_q == '0);

    for (genvar i = 0; i < NUM_CTRS; i++) begin : g_chk
        // R4: a group number of 8 or above never yields an increment.
        a_r4_no_group: assert property (@(posedge clk) disable iff (!rst_n)
            grp_flat[i*4+3] |-> !ctr_inc[i]);
    end
endmodule

bind evsel_top evsel_chk #(.NUM_CTRS(NUM_CTRS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sel_q    (sel_q),
    .grp_flat (grp_flat),
    .ctr_inc  (ctr_inc)
);

// File: tb/evsel_top_tb.sv
module evsel_top_tb;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [11:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [11:0]   rd_addr = '0;
    logic [31:0]   rd_data;
    logic [7:0]    evt_valid = '0;
    logic [63:0]   evt_code = '0;
    logic [15:0]   evt_sub = '0;
    logic [15:0]   evt_org = '0;
    logic [NC-1:0] ctr_inc;

    evsel_top #(.NUM_CTRS(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_sub(evt_sub),
        .evt_org(evt_org), .ctr_inc(ctr_inc)
    );

    always #10 clk = ~clk;

    // staged stimulus
    logic        s_wr = 1'b0;
    logic [11:0] s_wa = '0;
    logic [31:0] s_wd = '0;
    logic [11:0] s_ra = '0;
    logic [7:0]  s_val = '0;
    logic [63:0] s_code = '0;
    logic [15:0] s_sub = '0;
    logic [15:0] s_org = '0;

    // reference model
    logic [63:0] m_sel = '0;
    logic [3:0]  m_type [NC];
    logic [31:0] m_filt [NC];

    logic [31:0]   q_rd  [$];
    logic [NC-1:0] q_inc [$];
    string         q_tag [$];

    int checks = 0;
    int fails  = 0;

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        if (a == 12'h410) return m_sel[31:0];
        if (a == 12'h411) return m_sel[63:32];
        for (int i = 0; i < NC; i++) begin
            if (a == 12'h424 + 12'(16 * i)) return {28'd0, m_type[i]};
            if (a == 12'h423 + 12'(16 * i)) return m_filt[i];
        end
        return 32'd0;
    endfunction

    function automatic logic exp_one(input int i);
        int g;
        int sb;
        int og;
        g = int'(m_type[i]);
        if (g > 7 || !m_sel[63] || !s_val[g]) return 1'b0;
        if (s_code[8*g +: 8] != m_sel[8*g +: 8]) return 1'b0;
        sb = int'(s_sub[2*g +: 2]);
        og = int'(s_org[2*g +: 2]);
        if (sb == 3 || og == 3) return 1'b0;
        return m_filt[i][17 + sb] && m_filt[i][og];
    endfunction

    // driver: apply staged inputs, push expectations, then advance model
    task automatic cycle(input string tag);
        logic [NC-1:0] e;
        @(posedge clk);
        #1;
        wr_en = s_wr; wr_addr = s_wa; wr_data = s_wd; rd_addr = s_ra;
        evt_valid = s_val; evt_code = s_code; evt_sub = s_sub; evt_org = s_org;
        for (int i = 0; i < NC; i++) e[i] = exp_one(i);
        q_rd.push_back(exp_rd(s_ra));
        q_inc.push_back(e);
        q_tag.push_back(tag);
        if (s_wr) begin
            if (s_wa == 12'h410) m_sel[31:0] = s_wd;
            if (s_wa == 12'h411) m_sel[63:32] = s_wd;
            for (int i = 0; i < NC; i++) begin
                if (s_wa == 12'h424 + 12'(16 * i)) m_type[i] = s_wd[3:0];
                if (s_wa == 12'h423 + 12'(16 * i))
                    m_filt[i] = s_wd & 32'h000E_0007;
            end
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        s_wr = 1'b1; s_wa = a; s_wd = d;
        cycle(tag);
        s_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        s_ra = a;
        cycle(tag);
    endtask

    task automatic ev(input int g, input logic [7:0] c, input logic [1:0] sb,
                      input logic [1:0] og, input string tag);
        s_val = '0; s_val[g] = 1'b1;
        s_code[8*g +: 8] = c; s_sub[2*g +: 2] = sb; s_org[2*g +: 2] = og;
        cycle(tag);
        s_val = '0;
    endtask

    // monitor: compare outputs away from the active edge
    always @(negedge clk) begin
        while (q_rd.size() > 0) begin
            logic [31:0]   er;
            logic [NC-1:0] ei;
            string         t;
            er = q_rd.pop_front();
            ei = q_inc.pop_front();
            t  = q_tag.pop_front();
            checks += 2;
            if (rd_data !== er) begin
                fails++;
                $display("FAIL %s: rd_data actual %h expected %h", t, rd_data, er);
            end
            if (ctr_inc !== ei) begin
                fails++;
                $display("FAIL %s: ctr_inc actual %b expected %b", t, ctr_inc, ei);
            end
        end
    end

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NC; i++) begin
            m_type[i] = 4'hF;
            m_filt[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R7 reset state
        rd(12'h410, "R7 sel lo");
        rd(12'h411, "R7 sel hi");
        rd(12'h424, "R7 type0");
        rd(12'h443, "R7 filt2");
        // R1 halves, R4/R5 config
        wr(12'h411, 32'h8000_0000, "R1 hi write");
        wr(12'h410, 32'h005A_0000, "R1 lo write");
        rd(12'h411, "R1 hi read");
        rd(12'h410, "R1 lo read");
        wr(12'h424, 32'h2, "R4 type0");
        wr(12'h423, 32'h000E_0007, "R5 filt0 all");
        wr(12'h434, 32'h2, "R4 type1");
        wr(12'h433, 32'h0002_0001, "R5 filt1 narrow");
        wr(12'h444, 32'h9, "R4 type2 none");
        wr(12'h443, 32'h000E_0007, "R5 filt2");
        wr(12'h454, 32'h5, "R4 type3");
        wr(12'h453, 32'h000E_0007, "R5 filt3");
        rd(12'h444, "R4 type2 read");
        // R2/R6 matching
        ev(2, 8'h5A, 2'd0, 2'd0, "R6 group2 match both");
        ev(2, 8'h5B, 2'd0, 2'd0, "R2 wrong code");
        ev(3, 8'h5A, 2'd0, 2'd0, "R2 other group");
        ev(2, 8'h5A, 2'd1, 2'd0, "R5 subunit1 filtered");
        ev(2, 8'h5A, 2'd0, 2'd2, "R5 independent origin");
        ev(2, 8'h5A, 2'd3, 2'd0, "R5 subunit3 rejected");
        ev(2, 8'h5A, 2'd2, 2'd3, "R5 origin3 rejected");
        // R1 read-modify-write of group5 byte
        rd(12'h411, "R1 rmw read");
        wr(12'h411, m_sel[63:32] | 32'h0000_1100, "R1 rmw write");
        rd(12'h410, "R1 lo intact");
        ev(5, 8'h11, 2'd2, 2'd1, "R2 group5 match");
        ev(5, 8'h00, 2'd2, 2'd1, "R2 group5 old code");
        // R10 same-cycle write and event
        s_val = '0; s_val[2] = 1'b1; s_code[23:16] = 8'h5A;
        s_sub[5:4] = 2'd0; s_org[5:4] = 2'd0;
        wr(12'h410, 32'h0077_0000, "R10 event with sel write");
        ev(2, 8'h5A, 2'd0, 2'd0, "R10 old code gone");
        ev(2, 8'h77, 2'd0, 2'd0, "R10 new code");
        s_val = '0; s_val[2] = 1'b1; s_code[23:16] = 8'h77;
        wr(12'h424, 32'h5, "R10 event with type write");
        s_val = '0;
        ev(2, 8'h77, 2'd0, 2'd0, "R10 type moved");
        // R8 unmapped writes
        wr(12'h412, 32'hFFFF_FFFF, "R8 unmapped 412");
        wr(12'h425, 32'hFFFF_FFFF, "R8 unmapped 425");
        rd(12'h410, "R8 sel lo");
        rd(12'h411, "R8 sel hi");
        rd(12'h434, "R8 type1");
        // R9 unused bits
        wr(12'h433, 32'hFFFF_FFFF, "R9 filt1 all ones");
        rd(12'h433, "R9 filt1 read");
        wr(12'h444, 32'hFFFF_FFF7, "R9 type2 write");
        rd(12'h444, "R9 type2 read");
        ev(2, 8'h77, 2'd1, 2'd1, "R6 two counters group2");
        // R3 global disable
        s_val = '0; s_val[2] = 1'b1; s_code[23:16] = 8'h77;
        wr(12'h411, 32'h0000_1100, "R3 disable same cycle");
        s_val = '0;
        ev(2, 8'h77, 2'd0, 2'd0, "R3 disabled group2");
        ev(5, 8'h11, 2'd0, 2'd0, "R3 disabled group5");
        rd(12'h411, "R3 hi read");
        cycle("drain");
        @(posedge clk);
        @(negedge clk);
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule